// File: doc/BRIEF.md
# Match-and-Interval Timer Counter

A single 16-bit timer counter controlled through a small 32-bit register window. On each clock its count source is either the core clock or a synchronised external input. It can take the rising or the falling edge of that input. An optional power-of-two prescaler can divide the count source further. The counter runs upward or downward. It either wraps freely at its full range, which flags an overflow, or wraps at a programmable limit, which flags an interval event.

Three compare registers flag a match event when the counter steps onto their value, but only while match mode is on. The first compare also toggles a waveform output. That output returns to a programmable idle level on every wrap. Five event flags collect in a clear-on-read status register. The flags are masked by an enable register and ORed into one interrupt line.

Reads return data in the same cycle from `rd_en`/`addr`. Writes take effect at the clock edge that samples `wr_en`.

Top module: `prog_timer`

## Requirements
- R1: Offsets are 0x00 source setup, 0x0C run control, 0x18 count (read-only), 0x24 limit, 0x30/0x3C/0x48 compare 0/1/2, 0x54 event status, 0x60 event enable. After reset, run control reads 0x21, the count reads 0, status reads 0, and `irq` and `wave_out` are 0.
- R2: Run control bits are: bit0 halt, bit1 limit mode, bit2 count down, bit3 match mode, bit4 reload, bit5 waveform off, bit6 waveform idle level. With halt clear and an undivided core-clock source, the count rises by one per cycle. It first changes on the edge after the write that clears halt.
- R3: Writing run control with bit4 set loads the count one cycle later. The load value is 0 when counting up and the limit value when counting down. Bit4 always reads back 0.
- R4: With limit mode off, counting down from 0 gives 0xFFFF and sets status bit4 (overflow). Counting up from 0xFFFF gives 0 and also sets bit4.
- R5: In limit mode, counting up steps from the limit to 0 and counting down steps from 0 to the limit. Either wrap sets status bit0.
- R6: With match mode on, a step onto the value of compare k sets status bit k+1. With match mode off, no match bit is set.
- R7: A read of the status register returns the flags and clears them at the same edge. An event in that same cycle survives the clear.
- R8: `irq` is high exactly when some status bit and the same enable bit are both 1.
- R9: While bit5 is 0, `wave_out` toggles on each compare-0 match event. It returns to the bit6 level on a wrap or a reload. While bit5 is 1, `wave_out` is 0.
- R10: Source setup bit0 turns on the prescaler and bits 4:1 hold exponent N. The count then advances once per 2^(N+1) source ticks.
- R11: Source setup bit5 selects `ext_in` as the source, through a two-stage synchroniser. Bit6 selects the edge: 0 counts rising edges, 1 counts falling edges.
- R12: While halt is set, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a status read clears the flags |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, same cycle |
| ext_in | input | 1 | External count input, asynchronous |
| irq | output | 1 | Combined enabled event line |
| wave_out | output | 1 | Compare-driven waveform |

## Verification
Some properties are checked on every cycle. The count holds while halted. A reload lands on 0 or the limit. Both wraps land on the right value. A status read with no event leaves the flags empty. The prescaler never advances on two cycles in a row.

Other behaviour is shown only by the bench scenarios. These cover the exact step counts over a run, the divide ratio, and counting on chosen external edges. They also cover the gating of match flags by match mode, the masking of the interrupt line, and the waveform toggle and idle level.

// File: rtl/tmr_pkg.sv
// Shared constants and register field layouts for the timer counter.
// Assumes byte offsets and field positions are fixed by software usage.
package tmr_pkg;
    localparam int OFS_CLK    = 'h00;
    localparam int OFS_RUN    = 'h0C;
    localparam int OFS_CNT    = 'h18;
    localparam int OFS_LIM    = 'h24;
    localparam int OFS_CMP0   = 'h30;
    localparam int CMP_STRIDE = 12;
    localparam int OFS_STAT   = 'h54;
    localparam int OFS_ENA    = 'h60;
    localparam int PRE_W      = 4;

    // source setup: bit0 prescale on, 4:1 exponent, 5 external, 6 falling edge
    typedef struct packed {
        logic             edge_fall;
        logic             src_ext;
        logic [PRE_W-1:0] pre_exp;
        logic             pre_on;
    } clk_cfg_t;

    // run control: bit0 halt .. bit6 waveform idle level
    typedef struct packed {
        logic wave_pol;
        logic wave_off;
        logic cnt_clr;
        logic match_on;
        logic dir_down;
        logic ival_on;
        logic halt;
    } run_cfg_t;

    localparam run_cfg_t RUN_RST = 7'h21;
endpackage

// File: rtl/tmr_tick_gen.sv
// Count-source selection, external synchroniser/edge detect and prescaler.
// Assumes ext_in is asynchronous and slower than clk/2.
module tmr_tick_gen #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext,
    input  logic             edge_fall,
    input  logic             pre_on,
    input  logic [PRE_W-1:0] pre_exp,
    input  logic             ext_in,
    output logic             adv
);
    localparam int DIV_W = (1 << PRE_W) + 1;

    logic             sync1, sync2, sync3;
    logic             src_tick;
    logic [DIV_W-1:0] psc;
    logic [DIV_W-1:0] div_mask;

    // two-stage synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= ext_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    // pick the count source: every clock, or the selected external edge
    always_comb begin
        if (src_ext)
            src_tick = edge_fall ? (sync3 & ~sync2) : (sync2 & ~sync3);
        else
            src_tick = 1'b1;
    end

    // free-running source-tick counter used for division
    always_ff @(posedge clk) begin
        if (!rst_n)
            psc <= '0;
        else if (src_tick)
            psc <= psc + DIV_W'(1);
    end

    // advance once all low N+1 bits of the tick counter are ones
    always_comb begin
        div_mask = (DIV_W'(2) << pre_exp) - DIV_W'(1);
        adv      = src_tick && (!pre_on || ((psc & div_mask) == div_mask));
    end

    assert_prescale_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_on && adv) |=> !(pre_on && $stable(pre_exp) && adv));
endmodule

// File: rtl/tmr_core.sv
// Counter datapath: up/down stepping, free or limit wrap, compare events
// and the waveform flop. Assumes adv is a single-cycle enable.
module tmr_core #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           adv,
    input  logic                           clr,
    input  logic                           halt,
    input  logic                           ival_on,
    input  logic                           dir_down,
    input  logic                           match_on,
    input  logic                           wave_off,
    input  logic                           wave_pol,
    input  logic [CNT_W-1:0]               limit,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp,
    output logic [CNT_W-1:0]               cnt,
    output logic                           evt_ival,
    output logic                           evt_ovf,
    output logic [NUM_CMP-1:0]             evt_cmp,
    output logic                           wave_out
);
    logic             step, at_end, wrap;
    logic [CNT_W-1:0] wrap_val, nxt;
    logic             wave_q;

    // next-value and end-of-range detection
    always_comb begin
        step = adv && !halt && !clr;
        if (dir_down)
            at_end = (cnt == '0);
        else
            at_end = ival_on ? (cnt == limit) : (cnt == '1);
        if (dir_down)
            wrap_val = ival_on ? limit : '1;
        else
            wrap_val = '0;
        nxt      = at_end ? wrap_val : (dir_down ? cnt - CNT_W'(1) : cnt + CNT_W'(1));
        wrap     = step && at_end;
        evt_ival = wrap && ival_on;
        evt_ovf  = wrap && !ival_on;
    end

    // one compare event per compare register
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign evt_cmp[g] = step && match_on && (nxt == cmp[g]);
    end

    // count register: reload has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= dir_down ? limit : '0;
        else if (step)
            cnt <= nxt;
    end

    // waveform: idle level on wrap/reload/off, toggle on compare-0 event
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (wave_off || clr || wrap)
            wave_q <= wave_pol;
        else if (evt_cmp[0])
            wave_q <= ~wave_q;
    end

    assign wave_out = !wave_off && wave_q;

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt));
    assert_clr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == ($past(dir_down) ? $past(limit) : '0)));
    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !halt && !clr && dir_down && !ival_on && cnt == '0) |=> (cnt == '1));
    assert_ival_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !halt && !clr && ival_on && !dir_down && cnt == limit) |=> (cnt == '0));
endmodule

// File: rtl/tmr_regs.sv
// Register window: setup registers, reload pulse, compare values,
// clear-on-read event flags and interrupt combine. Same-cycle read data.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 3,
    parameter int EVT_W   = NUM_CMP + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [CNT_W-1:0]              cnt,
    input  logic [EVT_W-1:0]              evt,
    output logic [DATA_W-1:0]             rdata,
    output clk_cfg_t                      clk_cfg,
    output run_cfg_t                      run_cfg,
    output logic [CNT_W-1:0]              limit,
    output logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
    output logic                          irq
);
    logic             sel_clk, sel_run, sel_lim, sel_stat, sel_ena, rd_stat;
    logic [NUM_CMP-1:0] sel_cmp;
    clk_cfg_t         clk_q;
    run_cfg_t         run_q;
    logic             clr_q;
    logic [EVT_W-1:0] flags, ena;
    logic             unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    // address decode
    always_comb begin
        sel_clk  = (addr == ADDR_W'(OFS_CLK));
        sel_run  = (addr == ADDR_W'(OFS_RUN));
        sel_lim  = (addr == ADDR_W'(OFS_LIM));
        sel_stat = (addr == ADDR_W'(OFS_STAT));
        sel_ena  = (addr == ADDR_W'(OFS_ENA));
        rd_stat  = rd_en && sel_stat;
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign sel_cmp[g] = (addr == ADDR_W'(OFS_CMP0 + g * CMP_STRIDE));

        // compare value storage
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp[g] <= '0;
            else if (wr_en && sel_cmp[g])
                cmp[g] <= wdata[CNT_W-1:0];
        end
    end

    // setup registers and the one-cycle reload pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
            run_q <= RUN_RST;
            clr_q <= 1'b0;
            limit <= '0;
            ena   <= '0;
        end else begin
            clr_q <= 1'b0;
            if (wr_en && sel_clk)
                clk_q <= clk_cfg_t'(wdata[6:0]);
            if (wr_en && sel_run) begin
                run_q         <= run_cfg_t'(wdata[6:0]);
                run_q.cnt_clr <= 1'b0;
                clr_q         <= wdata[4];
            end
            if (wr_en && sel_lim)
                limit <= wdata[CNT_W-1:0];
            if (wr_en && sel_ena)
                ena <= wdata[EVT_W-1:0];
        end
    end

    // event flags: set by hardware, cleared by a status read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (rd_stat ? '0 : flags) | evt;
    end

    // expose the reload pulse in the run-control view
    always_comb begin
        clk_cfg         = clk_q;
        run_cfg         = run_q;
        run_cfg.cnt_clr = clr_q;
        irq             = |(flags & ena);
    end

    // same-cycle read multiplexer
    always_comb begin
        rdata = '0;
        if (sel_clk)  rdata = DATA_W'(clk_q);
        if (sel_run)  rdata = DATA_W'(run_q);
        if (addr == ADDR_W'(OFS_CNT)) rdata = DATA_W'(cnt);
        if (sel_lim)  rdata = DATA_W'(limit);
        if (sel_stat) rdata = DATA_W'(flags);
        if (sel_ena)  rdata = DATA_W'(ena);
        for (int i = 0; i < NUM_CMP; i++)
            if (sel_cmp[i]) rdata = DATA_W'(cmp[i]);
    end

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/prog_timer.sv
// Top level of the timer counter: ties the register window, the tick
// generator and the counter datapath together. Single clock domain.
module prog_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ext_in,
    output logic              irq,
    output logic              wave_out
);
    localparam int EVT_W = NUM_CMP + 2;

    clk_cfg_t                      clk_cfg;
    run_cfg_t                      run_cfg;
    logic [CNT_W-1:0]              limit, cnt;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
    logic                          adv, evt_ival, evt_ovf;
    logic [NUM_CMP-1:0]            evt_cmp;
    logic [EVT_W-1:0]              evt;

    // status bit order: bit0 limit wrap, compare events, top bit overflow
    assign evt = {evt_ovf, evt_cmp, evt_ival};

    tmr_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .NUM_CMP(NUM_CMP), .EVT_W(EVT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt(cnt), .evt(evt),
        .rdata(rdata), .clk_cfg(clk_cfg), .run_cfg(run_cfg),
        .limit(limit), .cmp(cmp), .irq(irq)
    );

    tmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .src_ext(clk_cfg.src_ext), .edge_fall(clk_cfg.edge_fall),
        .pre_on(clk_cfg.pre_on), .pre_exp(clk_cfg.pre_exp),
        .ext_in(ext_in), .adv(adv)
    );

    tmr_core #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_core (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(run_cfg.cnt_clr),
        .halt(run_cfg.halt), .ival_on(run_cfg.ival_on),
        .dir_down(run_cfg.dir_down), .match_on(run_cfg.match_on),
        .wave_off(run_cfg.wave_off), .wave_pol(run_cfg.wave_pol),
        .limit(limit), .cmp(cmp), .cnt(cnt),
        .evt_ival(evt_ival), .evt_ovf(evt_ovf), .evt_cmp(evt_cmp),
        .wave_out(wave_out)
    );
endmodule

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ext_in = 1'b0;
    logic [31:0] rdata;
    logic        irq, wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t       exp_q[$];
    logic [31:0] act_q[$];

    always #2 clk = ~clk;

    prog_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ext_in(ext_in),
        .irq(irq), .wave_out(wave_out)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back('{e, tag});
        #1 act_q.push_back(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin_chk(input logic v, input logic e, input string tag);
        exp_q.push_back('{{31'd0, e}, tag});
        act_q.push_back({31'd0, v});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: compare captured results against expected items in order
    initial forever begin
        @(posedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] a;
            it = exp_q.pop_front();
            a  = act_q.pop_front();
            checks++;
            if (a !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, a, it.exp);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd_chk(8'h0C, 32'h21, "R1 run control reset");
        rd_chk(8'h18, 32'h0,  "R1 count reset");
        rd_chk(8'h54, 32'h0,  "R1 status reset");
        pin_chk(irq, 1'b0, "R1 irq reset");
        pin_chk(wave_out, 1'b0, "R1 wave reset");

        // R2 up count, R12 hold
        wr(8'h0C, 32'h00); idle(9); wr(8'h0C, 32'h01);
        rd_chk(8'h18, 32'd10, "R2 up count of 10");
        idle(4);
        rd_chk(8'h18, 32'd10, "R12 halted count holds");

        // R3 reload up and down
        wr(8'h0C, 32'h11);
        rd_chk(8'h0C, 32'h01, "R3 reload bit reads 0");
        rd_chk(8'h18, 32'h0, "R3 reload to 0 when up");
        wr(8'h24, 32'd100); wr(8'h0C, 32'h15); idle(1);
        rd_chk(8'h18, 32'd100, "R3 reload to limit when down");

        // R5 down limit mode
        wr(8'h24, 32'd5); wr(8'h0C, 32'h17); idle(1);
        wr(8'h0C, 32'h06); idle(6); wr(8'h0C, 32'h07);
        rd_chk(8'h18, 32'd4, "R5 down limit wrap count");
        rd_chk(8'h54, 32'h01, "R5 limit wrap flag");
        rd_chk(8'h54, 32'h00, "R7 status cleared by read");

        // R4 down free wrap
        wr(8'h24, 32'd0); wr(8'h0C, 32'h15); idle(1);
        wr(8'h0C, 32'h04); idle(2); wr(8'h0C, 32'h05);
        rd_chk(8'h18, 32'hFFFD, "R4 down wrap to 0xFFFF");
        rd_chk(8'h54, 32'h10, "R4 overflow flag");

        // R5 up limit mode; R6 match off gives no match flag
        wr(8'h24, 32'd3); wr(8'h0C, 32'h13); idle(1);
        wr(8'h0C, 32'h02); idle(4); wr(8'h0C, 32'h03);
        rd_chk(8'h18, 32'd1, "R5 up limit wrap count");
        rd_chk(8'h54, 32'h01, "R6 no match flags with match mode off");

        // R6 match events, R9 toggle
        wr(8'h24, 32'd9); wr(8'h30, 32'd2); wr(8'h3C, 32'd4); wr(8'h48, 32'd7);
        wr(8'h0C, 32'h1B); idle(1);
        wr(8'h0C, 32'h0A); idle(4); wr(8'h0C, 32'h0B);
        rd_chk(8'h18, 32'd5, "R6 count at 5");
        pin_chk(wave_out, 1'b1, "R9 wave toggled on compare 0");

        // R8 interrupt masking
        wr(8'h60, 32'h08);
        pin_chk(irq, 1'b0, "R8 irq masked");
        wr(8'h60, 32'h04);
        pin_chk(irq, 1'b1, "R8 irq enabled");
        rd_chk(8'h54, 32'h06, "R6 compare 0 and 1 flags");
        pin_chk(irq, 1'b0, "R8 irq drops after clear");

        // R9 wrap restores idle level
        wr(8'h0C, 32'h0A); idle(4); wr(8'h0C, 32'h0B);
        rd_chk(8'h18, 32'd0, "R5 wrapped to 0");
        pin_chk(wave_out, 1'b0, "R9 wave back to idle on wrap");
        rd_chk(8'h54, 32'h09, "R6 compare 2 and limit flags");
        wr(8'h0C, 32'h51); idle(1);
        pin_chk(wave_out, 1'b1, "R9 idle level high after reload");
        wr(8'h0C, 32'h61);
        pin_chk(wave_out, 1'b0, "R9 waveform off");

        // R10 prescaler
        wr(8'h00, 32'h03); wr(8'h0C, 32'h11); idle(1);
        wr(8'h0C, 32'h00); idle(63); wr(8'h0C, 32'h01);
        rd_chk(8'h18, 32'd16, "R10 divide by 4");
        wr(8'h00, 32'h01); wr(8'h0C, 32'h11); idle(1);
        wr(8'h0C, 32'h00); idle(9); wr(8'h0C, 32'h01);
        rd_chk(8'h18, 32'd5, "R10 divide by 2");

        // R11 external rising then falling edges
        wr(8'h00, 32'h20); wr(8'h0C, 32'h11); idle(1); wr(8'h0C, 32'h00);
        for (int i = 0; i < 5; i++) begin
            ext_in = 1'b1; idle(3); ext_in = 1'b0; idle(3);
        end
        idle(6); wr(8'h0C, 32'h01);
        rd_chk(8'h18, 32'd5, "R11 rising edges counted");
        wr(8'h00, 32'h60); wr(8'h0C, 32'h11); idle(1); wr(8'h0C, 32'h00);
        for (int i = 0; i < 3; i++) begin
            ext_in = 1'b1; idle(3); ext_in = 1'b0; idle(3);
        end
        idle(6); wr(8'h0C, 32'h01);
        rd_chk(8'h18, 32'd3, "R11 falling edges counted");

        idle(3);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule